// File: doc/BRIEF.md
# Register Bank with Atomic Wide-Parameter Update

This block is the register file behind a byte-oriented serial control port. It sees the port as an abstract byte stream with four kinds of event: a start strobe that opens a transaction, a stop strobe that closes it, and data bytes that carry a read/write flag. After a start, the first byte written loads an 8-bit address pointer. Every later data byte, whether read or written, then reaches the register the pointer selects, and the pointer moves up by one. It wraps from 0xFF to 0x00.

Most registers are plain byte registers, and a write changes them at once. One 12-bit parameter is spread over two neighbouring addresses. The upper byte sits at the lower address and the low nibble at the next address. A write of the upper byte goes only into a shadow byte and sets a pending flag. The live parameter changes in a single step when the low-nibble register is written. Because of this, downstream logic never sees a half-updated value. Any other register write that comes between the two halves throws away the staged byte.

Top module: `param_regbank`

## Requirements
- R1: After reset the parameter output is 0, rd_valid is 0, every register reads back 0 and no upper byte is pending.
- R2: The first write byte after a start strobe loads the address pointer and changes no register or parameter.
- R3: Each data byte that is read or written advances the pointer by one, and address 0xFF is followed by 0x00.
- R4: A write to a plain register at an address below NUM_REGS (64 by default), other than 0x34 and 0x35, takes effect at once and reads back. Addresses at or above NUM_REGS read 0 and ignore writes.
- R5: A read byte strobe is answered in the next cycle: rd_valid is 1 for one cycle and rd_data carries the selected register.
- R6: Writing address 0x34 alone leaves the parameter unchanged. A read of 0x34 returns the committed bits [11:4], never the shadow.
- R7: A write to 0x34 followed directly by a write to 0x35 sets the parameter to {byte written to 0x34, bits [3:0] of the byte written to 0x35}. All 12 bits change in the cycle after the 0x35 write.
- R8: A write to any other register between the 0x34 and 0x35 writes discards the staged byte. The next 0x35 write keeps the committed upper bits.
- R9: A write to 0x35 with nothing pending commits the committed bits [11:4] joined with the new bits [3:0].
- R10: A read of 0x35 returns the committed bits [3:0] in rd_data[3:0], and rd_data[7:4] is 0.
- R11: A stop neither commits nor discards a pending upper byte. A pointer load in a new transaction also leaves it pending.
- R12: Data bytes received between a stop and the next start, or in the same cycle as a start or stop strobe, are ignored. They change no register and no pointer, and a read there raises no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Start of transaction; the next write byte is a pointer load |
| xfer_stop | input | 1 | End of transaction |
| byte_valid | input | 1 | A data byte is present this cycle |
| byte_wr | input | 1 | 1 = byte written to the block, 0 = byte read from it |
| byte_in | input | 8 | Written byte value |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result strobe, one cycle after the read byte |
| param_value | output | 12 | Committed wide parameter |

## Verification
The bench builds the block with its default values: a 64-entry backed bank and the parameter pair at 0x34/0x35. With these values, about three quarters of the address space is unbacked. Random pointer loads therefore reach both stored and read-as-zero registers. A pointer load of 0xFF followed by two data bytes walks the wrap from unbacked space back into stored space. Random stimulus is weighted toward addresses 0x33 to 0x36. This makes interrupted, ordered and lone-half parameter writes frequent, together with the stop-separated sequences.

// File: rtl/param_regbank_pkg.sv
// Shared types for the register bank.
// Assumes: a single clock domain and byte-wide registers.
package param_regbank_pkg;

    // Transaction phase seen by the pointer unit.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // outside a transaction
        PH_ADDR = 2'd1,   // next write byte loads the pointer
        PH_DATA = 2'd2    // bytes address registers
    } xfer_phase_t;

endpackage

// File: rtl/param_regbank_pointer.sv
// Address pointer and transaction phase tracker.
// Turns the byte stream into register write and read enables at the current pointer.
// Assumes: a start or stop strobe in the same cycle as a byte makes that byte ignored.
module param_regbank_pointer
    import param_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              byte_valid,
    input  logic              byte_wr,
    input  logic [ADDR_W-1:0] byte_in,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              in_xfer
);

    xfer_phase_t phase;
    logic        accept;
    logic        load_ptr;

    // Classify the current byte against the transaction phase.
    always_comb begin
        accept   = byte_valid && !xfer_start && !xfer_stop && (phase != PH_IDLE);
        load_ptr = accept && byte_wr && (phase == PH_ADDR);
        wr_en    = accept && byte_wr && (phase == PH_DATA);
        rd_en    = accept && !byte_wr;
        in_xfer  = (phase != PH_IDLE);
    end

    // Phase sequencing and pointer load/advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ptr   <= '0;
        end else if (xfer_start) begin
            phase <= PH_ADDR;
        end else if (xfer_stop) begin
            phase <= PH_IDLE;
        end else if (load_ptr) begin
            ptr   <= byte_in;
            phase <= PH_DATA;
        end else if (wr_en || rd_en) begin
            ptr   <= ptr + 1'b1;
            phase <= PH_DATA;
        end
    end

endmodule

// File: rtl/param_regbank_store.sv
// Plain byte registers that take a write at once.
// Addresses used by the wide parameter, and addresses at or above NUM_REGS, have no storage and read as zero.
// Assumes: NUM_REGS <= 2**ADDR_W.
module param_regbank_store #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 64,
    parameter int HI_ADDR  = 'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int LO_ADDR = HI_ADDR + 1;

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == HI_ADDR || i == LO_ADDR) begin : g_hole
            assign mem[i] = '0;
        end else begin : g_ff
            // Update one stored byte when it is addressed by a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (wr_en && addr == ADDR_W'(i))
                    mem[i] <= wdata;
            end
        end
    end

    // Select the addressed byte; unbacked addresses return zero.
    always_comb begin
        if (int'(addr) < NUM_REGS)
            rdata = mem[addr[IDX_W-1:0]];
        else
            rdata = '0;
    end

endmodule

// File: rtl/param_regbank_commit.sv
// Shadow stage and atomic commit for the wide parameter.
// The upper byte goes to HI_ADDR and the low bits to HI_ADDR+1.
// Assumes: PARAM_W is greater than DATA_W and at most 2*DATA_W.
module param_regbank_commit #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int PARAM_W = 12,
    parameter int HI_ADDR = 'h34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [PARAM_W-1:0] param_value,
    output logic               pending,
    output logic [DATA_W-1:0]  hi_rd,
    output logic [DATA_W-1:0]  lo_rd
);

    localparam int LO_W = PARAM_W - DATA_W;
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(HI_ADDR + 1);

    logic [DATA_W-1:0] shadow_hi;
    logic [DATA_W-1:0] next_hi;

    // Pick the upper bits for a commit: staged if pending, else committed.
    always_comb begin
        next_hi = pending ? shadow_hi : param_value[PARAM_W-1:LO_W];
        hi_rd   = param_value[PARAM_W-1:LO_W];
        lo_rd   = {{(DATA_W-LO_W){1'b0}}, param_value[LO_W-1:0]};
    end

    // Stage, commit or discard on each register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_hi   <= '0;
            pending     <= 1'b0;
            param_value <= '0;
        end else if (wr_en) begin
            if (addr == HI_A) begin
                shadow_hi <= wdata;
                pending   <= 1'b1;
            end else if (addr == LO_A) begin
                param_value <= {next_hi, wdata[LO_W-1:0]};
                shadow_hi   <= '0;
                pending     <= 1'b0;
            end else begin
                shadow_hi <= '0;
                pending   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/param_regbank.sv
// Register bank behind a byte-stream control port, with one wide parameter committed atomically.
// Assumes: one clock and a synchronous active-low reset.
module param_regbank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 64,
    parameter int PARAM_W  = 12,
    parameter int HI_ADDR  = 'h34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_start,
    input  logic               xfer_stop,
    input  logic               byte_valid,
    input  logic               byte_wr,
    input  logic [DATA_W-1:0]  byte_in,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [PARAM_W-1:0] param_value
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(HI_ADDR + 1);

    logic [ADDR_W-1:0] ptr;
    logic              wr_en;
    logic              rd_en;
    logic              in_xfer;
    logic              pending;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] hi_rd;
    logic [DATA_W-1:0] lo_rd;
    logic [DATA_W-1:0] rd_sel;

    param_regbank_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .byte_valid(byte_valid), .byte_wr(byte_wr), .byte_in(byte_in[ADDR_W-1:0]),
        .ptr(ptr), .wr_en(wr_en), .rd_en(rd_en), .in_xfer(in_xfer)
    );

    param_regbank_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .HI_ADDR(HI_ADDR)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wdata(byte_in),
        .rdata(store_rd)
    );

    param_regbank_commit #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARAM_W(PARAM_W), .HI_ADDR(HI_ADDR)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wdata(byte_in),
        .param_value(param_value), .pending(pending), .hi_rd(hi_rd), .lo_rd(lo_rd)
    );

    // Route the addressed register to the read path.
    always_comb begin
        if (ptr == HI_A)
            rd_sel = hi_rd;
        else if (ptr == LO_A)
            rd_sel = lo_rd;
        else
            rd_sel = store_rd;
    end

    // Register the read response one cycle after the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= rd_sel;
        end
    end

endmodule

// File: rtl/param_regbank_checker.sv
// Temporal checks on the register bank, attached to every instance by bind.
// Assumes: the same parameters as the bound instance.
module param_regbank_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int PARAM_W = 12,
    parameter int HI_ADDR = 'h34
) (
    input logic               clk,
    input logic               rst_n,
    input logic               byte_valid,
    input logic               byte_wr,
    input logic               in_xfer,
    input logic               wr_en,
    input logic               rd_en,
    input logic               pending,
    input logic [ADDR_W-1:0]  ptr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               rd_valid,
    input logic [PARAM_W-1:0] param_value
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(HI_ADDR + 1);
    localparam int LO_W = PARAM_W - DATA_W;

    // R6: the parameter only moves after a write to the low register
    assert_param_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ptr == LO_A) |=> $stable(param_value));

    // R3: each accepted data byte advances the pointer by one
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |=> ptr == $past(ptr) + 1'b1);

    // R5: a read response follows a read byte strobe
    assert_rd_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(byte_valid && !byte_wr));

    // R10: reserved bits of the low register read as zero
    assert_lo_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ptr == LO_A) |=> rd_data[DATA_W-1:LO_W] == '0);

    // R8: a write elsewhere drops a pending upper byte
    assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr != HI_A && ptr != LO_A) |=> !pending);

    // R7: a low-register write always leaves nothing pending
    assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == LO_A) |=> !pending);

    // R12: bytes outside a transaction leave the pointer alone
    assert_idle_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !in_xfer) |=> $stable(ptr));

endmodule

bind param_regbank param_regbank_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARAM_W(PARAM_W), .HI_ADDR(HI_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_wr(byte_wr),
    .in_xfer(in_xfer), .wr_en(wr_en), .rd_en(rd_en), .pending(pending),
    .ptr(ptr), .rd_data(rd_data), .rd_valid(rd_valid), .param_value(param_value)
);

// File: tb/param_regbank_bench.sv
// Self-checking bench: directed corner cases followed by seeded random transactions,
// compared against a behavioural model kept in bench variables.
module param_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_wr = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [11:0] param_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // model state
    logic [7:0]  m_regs [256];
    logic [11:0] m_param;
    logic [7:0]  m_shadow;
    bit          m_pend;
    logic [7:0]  m_ptr;
    int          m_phase;   // 0 idle, 1 pointer phase, 2 data phase

    always #2.5 clk = ~clk;   // 200 MHz

    param_regbank u_param_regbank (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .byte_valid(byte_valid), .byte_wr(byte_wr), .byte_in(byte_in),
        .rd_data(rd_data), .rd_valid(rd_valid), .param_value(param_value)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h34) return m_param[11:4];
        if (a == 8'h35) return {4'h0, m_param[3:0]};
        if (a < 8'd64)  return m_regs[a];
        return 8'h00;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h34) begin
            m_shadow = d; m_pend = 1'b1;
        end else if (a == 8'h35) begin
            m_param  = {m_pend ? m_shadow : m_param[11:4], d[3:0]};
            m_pend   = 1'b0; m_shadow = 8'h00;
        end else begin
            m_pend = 1'b0; m_shadow = 8'h00;
            if (a < 8'd64) m_regs[a] = d;
        end
    endfunction

    task automatic do_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        m_phase = 1;
    endtask

    task automatic do_stop();
        @(negedge clk); xfer_stop = 1'b1;
        @(negedge clk); xfer_stop = 1'b0;
        m_phase = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_wr = 1'b1; byte_in = d;
        @(negedge clk); byte_valid = 1'b0;
        if (m_phase == 1) begin
            m_ptr = d; m_phase = 2;
        end else if (m_phase == 2) begin
            model_write(m_ptr, d); m_ptr = m_ptr + 8'd1;
        end
    endtask

    task automatic rd_byte(input string tag);
        logic [7:0] e;
        @(negedge clk); byte_valid = 1'b1; byte_wr = 1'b0;
        @(negedge clk); byte_valid = 1'b0;
        if (m_phase == 0) begin
            check(rd_valid, 0, tag);
        end else begin
            e = model_read(m_ptr);
            m_ptr = m_ptr + 8'd1; m_phase = 2;
            check(rd_valid, 1, tag);
            check(rd_data, e, tag);
        end
    endtask

    task automatic read_at(input logic [7:0] a, input string tag);
        do_start(); wr_byte(a); rd_byte(tag); do_stop();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus and checks.
    initial begin
        int seed;
        logic [7:0] a;
        for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
        m_param = 12'h000; m_shadow = 8'h00; m_pend = 1'b0; m_ptr = 8'h00; m_phase = 0;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(param_value, 12'h000, "R1 param after reset");
        check(rd_valid, 0, "R1 rd_valid after reset");
        read_at(8'h10, "R1 reg 0x10 after reset");
        read_at(8'h34, "R1 0x34 after reset");

        // R2 and R4: pointer load then immediate write
        do_start(); wr_byte(8'h12);
        check(param_value, 12'h000, "R2 pointer load leaves param");
        wr_byte(8'hA5); wr_byte(8'h5A); do_stop();
        read_at(8'h12, "R4 reg 0x12");
        read_at(8'h13, "R4 reg 0x13");
        // R4: unbacked address ignores writes
        do_start(); wr_byte(8'h80); wr_byte(8'h77); do_stop();
        read_at(8'h80, "R4 unbacked reads zero");

        // R6 and R7: ordered pair
        do_start(); wr_byte(8'h34); wr_byte(8'hC3);
        check(param_value, 12'h000, "R6 upper byte alone");
        rd_byte("R3 read after 0x34 goes to 0x35");
        do_stop();
        read_at(8'h34, "R6 0x34 reads committed");
        do_start(); wr_byte(8'h34); wr_byte(8'hC3); wr_byte(8'hF9);
        check(param_value, 12'hC39, "R7 atomic commit");
        do_stop();
        read_at(8'h35, "R10 low read reserved zero");

        // R8: interrupted sequence
        do_start(); wr_byte(8'h34); wr_byte(8'h11); do_stop();
        do_start(); wr_byte(8'h20); wr_byte(8'h99); do_stop();
        do_start(); wr_byte(8'h35); wr_byte(8'h04);
        check(param_value, 12'hC34, "R8 discarded staged byte");
        do_stop();

        // R9: low write without pending
        do_start(); wr_byte(8'h35); wr_byte(8'hEB);
        check(param_value, 12'hC3B, "R9 lone low write");
        do_stop();

        // R11: stop between halves keeps pending
        do_start(); wr_byte(8'h34); wr_byte(8'h6D); do_stop();
        check(param_value, 12'hC3B, "R11 stop does not commit");
        do_start(); wr_byte(8'h35); wr_byte(8'h02);
        check(param_value, 12'h6D2, "R11 pending survives stop");
        do_stop();

        // R3: wrap from 0xFF to 0x00
        do_start(); wr_byte(8'h00); wr_byte(8'h3C); do_stop();
        do_start(); wr_byte(8'hFF); rd_byte("R3 read 0xFF"); rd_byte("R3 wrap to 0x00"); do_stop();

        // R12: bytes outside a transaction
        wr_byte(8'h4E);
        rd_byte("R12 idle read no valid");
        read_at(8'h01, "R12 idle write ignored");
        do_start(); wr_byte(8'h02);
        @(negedge clk); xfer_stop = 1'b1; byte_valid = 1'b1; byte_wr = 1'b1; byte_in = 8'hEE;
        @(negedge clk); xfer_stop = 1'b0; byte_valid = 1'b0; m_phase = 0;
        read_at(8'h02, "R12 byte with stop ignored");

        // Random transactions weighted toward the parameter pair (R4 R5 R7 R8 R9 R11).
        for (int t = 0; t < 400; t++) begin
            do_start();
            if ($urandom_range(0, 9) != 0) begin
                case ($urandom_range(0, 3))
                    0: a = 8'h33;
                    1: a = 8'h34;
                    2: a = 8'h35;
                    default: a = 8'($urandom_range(0, 255));
                endcase
                wr_byte(a);
            end
            for (int b = 0; b < int'($urandom_range(1, 4)); b++) begin
                if ($urandom_range(0, 2) != 0) begin
                    wr_byte(8'($urandom));
                    check(param_value, m_param, "R7 random param");
                end else begin
                    rd_byte("R5 random read");
                end
            end
            do_stop();
            if ($urandom_range(0, 7) == 0) wr_byte(8'($urandom));
        end

        finish_run();
    end

endmodule